// File: doc/BRIEF.md
# Running Peak Score and Coordinate Tracker

This block sits beside a linear systolic alignment array. On every clock cycle it gets one packed bus that carries the current cell score of every array element. In a cycle flagged valid, it picks the highest score on the bus and the element that holds it, all within that cycle. It then compares that winner with a stored running maximum, which covers every valid cycle since the last clear.

Whenever the running maximum is replaced, the block also stores two coordinates of the winning cell. The query coordinate is the element index. The subject coordinate is the valid-cycle count minus that element index. The subtraction removes the one-cycle-per-element skew of the systolic array. A clear pulse before each new alignment sets the stored peak, both coordinates and the cycle count back to zero.

Top module: `sw_peak_tracker`

## Requirements
- R1: While `rst_ni` is low, `peak_o`, `best_q_o` and `best_s_o` are all zero. This holds asynchronously, with no clock edge needed.
- R2: After the clock edge of a valid cycle, `peak_o` becomes the largest element score on `scores_i` if that score is strictly greater than the stored peak. Element k occupies bits [k*SCORE_W +: SCORE_W].
- R3: When the peak updates, `best_q_o` becomes the index of the winning element. If several elements tie for the top score in the same cycle, the lowest index wins.
- R4: A score equal to the stored peak in a later cycle does not update the peak or either coordinate, so the earliest cycle wins.
- R5: When the peak updates, `best_s_o` becomes (n − `best_q_o`) mod 2^SUBJ_W. Here n is the number of valid cycles since the last clear or reset that came before this cycle, so the first valid cycle has n = 0.
- R6: A cycle with `valid_i` low changes no output and does not advance n.
- R7: A cycle with `clear_i` high zeroes all three outputs and restarts n at 0. This happens even when `valid_i` is also high, and that cycle's scores are discarded.
- R8: Scores are unsigned. An all-zero valid cycle never updates anything, and the full-scale value 2^SCORE_W − 1 is tracked exactly.
- R9: Without a clear or reset, `peak_o` never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous restart before a new alignment |
| valid_i | input | 1 | Scores on the bus are to be compared this cycle |
| scores_i | input | N_PE*SCORE_W | Packed element scores, element 0 in the low bits |
| peak_o | output | SCORE_W | Running maximum score |
| best_q_o | output | IDX_W | Element (query) index of the peak |
| best_s_o | output | SUBJ_W | Subject index of the peak |

## Verification
All three results are registered. A stimulus driven before a rising edge shows up on the outputs right after that edge, with a latency of one cycle. A clear behaves the same way. Reset is the only asynchronous path and takes effect at once. The bench changes inputs on the falling edge and checks the outputs on the next falling edge. Each check therefore sees exactly the edge that took in its stimulus, and the expected subject index is worked out by hand from the number of valid cycles driven since the last clear.

// File: rtl/sw_peak_pkg.sv
package sw_peak_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/peak_argmax.sv
module peak_argmax
  import sw_peak_pkg::*;
#(
  parameter int N_PE    = 8,
  parameter int SCORE_W = 21,
  localparam int IDX_W  = idx_width(N_PE)
) (
  input  logic [N_PE*SCORE_W-1:0] scores_i,
  output logic [SCORE_W-1:0]      max_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [SCORE_W-1:0] run_v [N_PE];
  logic [IDX_W-1:0]   run_i [N_PE];

  // prefix chain: stage k holds best of elements 0..k, strict compare keeps lowest index
  for (genvar k = 0; k < N_PE; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign run_v[k] = scores_i[SCORE_W-1:0];
      assign run_i[k] = '0;
    end else begin : g_next
      logic take;
      assign take     = scores_i[k*SCORE_W +: SCORE_W] > run_v[k-1];
      assign run_v[k] = take ? scores_i[k*SCORE_W +: SCORE_W] : run_v[k-1];
      assign run_i[k] = take ? IDX_W'(k) : run_i[k-1];
    end
  end

  assign max_o = run_v[N_PE-1];
  assign idx_o = run_i[N_PE-1];
endmodule

// File: rtl/subj_counter.sv
module subj_counter #(
  parameter int SUBJ_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              valid_i,
  output logic [SUBJ_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clear_i) cnt_o <= '0;
    else if (valid_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/peak_hold.sv
module peak_hold #(
  parameter int SCORE_W = 21,
  parameter int IDX_W   = 3,
  parameter int SUBJ_W  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               valid_i,
  input  logic [SCORE_W-1:0] cand_v_i,
  input  logic [IDX_W-1:0]   cand_q_i,
  input  logic [SUBJ_W-1:0]  cand_s_i,
  output logic [SCORE_W-1:0] peak_o,
  output logic [IDX_W-1:0]   best_q_o,
  output logic [SUBJ_W-1:0]  best_s_o
);
  logic upd;
  assign upd = valid_i && (cand_v_i > peak_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_o   <= '0;
      best_q_o <= '0;
      best_s_o <= '0;
    end else if (clear_i) begin
      peak_o   <= '0;
      best_q_o <= '0;
      best_s_o <= '0;
    end else if (upd) begin
      peak_o   <= cand_v_i;
      best_q_o <= cand_q_i;
      best_s_o <= cand_s_i;
    end
  end
endmodule

// File: rtl/sw_peak_tracker.sv
module sw_peak_tracker
  import sw_peak_pkg::*;
#(
  parameter int N_PE    = 8,
  parameter int SCORE_W = 21,
  parameter int SUBJ_W  = 12,
  localparam int IDX_W  = idx_width(N_PE)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    valid_i,
  input  logic [N_PE*SCORE_W-1:0] scores_i,
  output logic [SCORE_W-1:0]      peak_o,
  output logic [IDX_W-1:0]        best_q_o,
  output logic [SUBJ_W-1:0]       best_s_o
);
  logic [SCORE_W-1:0] cyc_max;
  logic [IDX_W-1:0]   cyc_idx;
  logic [SUBJ_W-1:0]  cnt;
  logic [SUBJ_W-1:0]  cand_s;

  peak_argmax #(.N_PE(N_PE), .SCORE_W(SCORE_W)) u_argmax (
    .scores_i (scores_i),
    .max_o    (cyc_max),
    .idx_o    (cyc_idx)
  );

  subj_counter #(.SUBJ_W(SUBJ_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .valid_i (valid_i),
    .cnt_o   (cnt)
  );

  // undo systolic skew: element i sees subject char (cycle - i)
  assign cand_s = cnt - SUBJ_W'(cyc_idx);

  peak_hold #(.SCORE_W(SCORE_W), .IDX_W(IDX_W), .SUBJ_W(SUBJ_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .valid_i  (valid_i),
    .cand_v_i (cyc_max),
    .cand_q_i (cyc_idx),
    .cand_s_i (cand_s),
    .peak_o   (peak_o),
    .best_q_o (best_q_o),
    .best_s_o (best_s_o)
  );
endmodule

// File: rtl/sw_peak_tracker_chk.sv
module sw_peak_tracker_chk
  import sw_peak_pkg::*;
#(
  parameter int N_PE    = 8,
  parameter int SCORE_W = 21,
  parameter int SUBJ_W  = 12,
  localparam int IDX_W  = idx_width(N_PE)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    clear_i,
  input logic                    valid_i,
  input logic [N_PE*SCORE_W-1:0] scores_i,
  input logic [SCORE_W-1:0]      peak_o,
  input logic [IDX_W-1:0]        best_q_o,
  input logic [SUBJ_W-1:0]       best_s_o
);
  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (peak_o == '0 && best_q_o == '0 && best_s_o == '0));

  p_no_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> peak_o >= $past(peak_o));

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !valid_i) |=> ($stable(peak_o) && $stable(best_q_o) && $stable(best_s_o)));

  p_qidx_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(best_q_o) < N_PE);

  for (genvar k = 0; k < N_PE; k++) begin : g_cover
    p_peak_covers_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !clear_i) |=> peak_o >= $past(scores_i[k*SCORE_W +: SCORE_W]));
  end
endmodule

bind sw_peak_tracker sw_peak_tracker_chk #(
  .N_PE(N_PE), .SCORE_W(SCORE_W), .SUBJ_W(SUBJ_W)
) u_chk (.*);

// File: tb/sw_peak_tracker_test.sv
module sw_peak_tracker_test;
  localparam int N  = 8;
  localparam int SW = 21;
  localparam int JW = 12;
  localparam int IW = 3;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              clear_i = 1'b0;
  logic              valid_i = 1'b0;
  logic [N*SW-1:0]   scores_i = '0;
  logic [SW-1:0]     peak_o;
  logic [IW-1:0]     best_q_o;
  logic [JW-1:0]     best_s_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sw_peak_tracker #(.N_PE(N), .SCORE_W(SW), .SUBJ_W(JW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .valid_i(valid_i),
    .scores_i(scores_i), .peak_o(peak_o), .best_q_o(best_q_o), .best_s_o(best_s_o)
  );

  task automatic expect3(input string req, input int pk, input int q, input int s);
    n_chk++;
    if (int'(peak_o) != pk || int'(best_q_o) != q || int'(best_s_o) != s) begin
      n_bad++;
      $display("FAIL %s: got peak=%0d q=%0d s=%0d, expected peak=%0d q=%0d s=%0d",
               req, peak_o, best_q_o, best_s_o, pk, q, s);
    end
  endtask

  // drive at negedge, one posedge, sample at next negedge
  task automatic step(input bit v, input bit c, input logic [N*SW-1:0] sc);
    valid_i = v; clear_i = c; scores_i = sc;
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0; clear_i = 1'b0; scores_i = '0;
  endtask

  function automatic logic [N*SW-1:0] one(input int k, input int v);
    logic [N*SW-1:0] r = '0;
    r[k*SW +: SW] = SW'(v);
    return r;
  endfunction

  task automatic t_reset;
    expect3("R1 in reset", 0, 0, 0);
    @(negedge clk); rst_ni = 1'b1;
    step(1'b0, 1'b0, '0);
    expect3("R1 after release", 0, 0, 0);
  endtask

  task automatic t_basic;
    step(1'b0, 1'b1, '0);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b0, '0);
      expect3("R8 zero cycle", 0, 0, 0);
    end
    step(1'b1, 1'b0, one(2, 5));                    // n=3
    expect3("R2 R5 first peak", 5, 2, 1);
    step(1'b1, 1'b0, one(1, 9) | one(3, 9));        // n=4
    expect3("R3 lowest index tie", 9, 1, 3);
    step(1'b1, 1'b0, one(0, 9));                    // n=5
    expect3("R4 equal later ignored", 9, 1, 3);
    step(1'b1, 1'b0, one(0, 4));                    // n=6
    expect3("R9 smaller kept", 9, 1, 3);
  endtask

  task automatic t_invalid;
    step(1'b0, 1'b0, one(7, 1000));
    expect3("R6 invalid ignored", 9, 1, 3);
    step(1'b1, 1'b0, one(7, 20));                   // n=7: 7-7=0
    expect3("R6 R5 count not advanced", 20, 7, 0);
  endtask

  task automatic t_clear;
    step(1'b1, 1'b1, one(4, 5000));
    expect3("R7 clear beats valid", 0, 0, 0);
    step(1'b1, 1'b0, one(0, 1));                    // n=0
    expect3("R7 count restarts", 1, 0, 0);
  endtask

  task automatic t_fullscale;
    step(1'b1, 1'b0, one(4, (1 << SW) - 1));       // n=1: 1-4 mod 4096
    expect3("R8 R5 full scale wrap", (1 << SW) - 1, 4, 4093);
    step(1'b1, 1'b0, one(6, 7) | one(5, 300));      // n=2
    expect3("R9 full scale held", (1 << SW) - 1, 4, 4093);
  endtask

  task automatic t_async;
    @(negedge clk); #1 rst_ni = 1'b0;
    #0.5 expect3("R1 async clear", 0, 0, 0);
    @(negedge clk); rst_ni = 1'b1;
    step(1'b1, 1'b0, one(3, 11));                   // n=0: 0-3
    expect3("R1 R5 count reset", 11, 3, 4093);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_invalid();
    t_clear();
    t_fullscale();
    t_async();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule